// File: doc/BRIEF.md
# MII Management Command Sequencer

This block lets a host reach the registers of an external Ethernet PHY through a handful of byte-wide mapped registers. The host sets a 5-bit PHY register number, then starts an operation. To read, it sets a request bit in a command register. To write, it loads the low data byte and then the high data byte, and the high-byte write is what starts the transaction. The block then produces one complete serial management frame on a clock/data pair: a divided management clock and a data line with a separate output enable. It holds a busy flag for the whole frame. On a read it captures the 16 data bits the PHY returns.

A read result may be used only once busy has dropped. A "read data not valid" flag is set when a read starts and is cleared on the same clock edge on which busy falls. The management clock is produced from the system clock by a fixed divider parameter. The PHY address placed in each frame is a parameter of the block.

Top module: `mii_mgmt_seq`

## Requirements
- R1: After reset the status register reads 0x04 (busy clear, scan-active clear, not-valid set). Both read-data bytes read 0. `mdc` is low and `mdio_oe` is low.
- R2: A write to the command register (index 1) with bit 0 set, made while idle, starts a read frame. Busy (status bit 0) is set from the next clock and the not-valid flag (status bit 2) is set with it.
- R3: A write to the data-high register (index 3) while idle starts a write frame carrying {high byte, stored low byte}. A write to the data-low register (index 2) on its own starts nothing.
- R4: Busy stays set for exactly 64 bit periods, that is 64 × 2 × MDC_HALF clocks, and then clears.
- R5: During a frame every bit period has `mdc` low for MDC_HALF clocks followed by high for MDC_HALF clocks. `mdc` is low whenever the block is idle.
- R6: The frame is sent MSB first, with `mdio_o` changing only while `mdc` is low. Its fields are 32 ones, start code 01, opcode (10 for a read, 01 for a write), the PHY_ADDR parameter (5 bits), the register number (5 bits), turnaround (10 on a write), and 16 data bits.
- R7: On a write `mdio_oe` is high for all 64 bits. On a read it is high for bits 0–45 and low for the turnaround and the 16 data bits. Returned bits are sampled in the last system clock of each `mdc`-high half.
- R8: When a read frame ends, the read-data registers take the 16 sampled bits (high byte at index 5, low byte at index 4) and the not-valid flag clears, on the edge on which busy falls. A write frame changes neither.
- R9: While busy, writes to indices 0–3 are discarded. They neither start a new frame nor change any stored value.
- R10: The command register stores its bits 1:0 and reads them back. Bit 1 (scan request) starts no frame, and status bit 1 (scan active) always reads 0.
- R11: Register indices: 0 register number (bits 4:0, upper bits read 0), 1 command, 2 data low, 3 data high, 4 read low, 5 read high, 6 status, 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index for write and read-back |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read-back of the indexed register (combinational) |
| mdio_i | input | 1 | Serial data returned by the PHY |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data toward the PHY |
| mdio_oe | output | 1 | Output enable for `mdio_o` |

## Verification
Several properties are checked on every clock:
- busy follows a launch by one clock;
- busy lasts exactly one frame length, measured by an independent counter;
- `mdc` is low when a frame begins and when it ends;
- `mdio_o` never moves while `mdc` is high;
- the not-valid flag and the read data settle on the edge that ends a read;
- the register number holds while a write arrives during busy.

Frame contents, the release of the data line during turnaround, and the round trip of data through a PHY model are shown only by the bench's scenarios. The same is true of the identifier values, the inertness of the scan bit, and the full set of triggers ignored during busy. The bench sweeps writes and reads over all 32 register numbers against arithmetically generated data.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;

    localparam int PREAMBLE_BITS = 32;
    localparam int FRAME_BITS    = 64;
    localparam int BIT_W         = $clog2(FRAME_BITS);
    localparam int REG_AW        = 5;
    localparam int DATA_W        = 16;
    localparam int TA_FIRST_BIT  = 46;

    typedef enum logic {
        OP_RD = 1'b0,
        OP_WR = 1'b1
    } mgmt_op_e;

    typedef enum logic [2:0] {
        RI_REGNUM = 3'd0,
        RI_CMD    = 3'd1,
        RI_WLO    = 3'd2,
        RI_WHI    = 3'd3,
        RI_RLO    = 3'd4,
        RI_RHI    = 3'd5,
        RI_STAT   = 3'd6,
        RI_NONE   = 3'd7
    } reg_idx_e;

    // Whole serial frame, most significant bit sent first.
    function automatic logic [FRAME_BITS-1:0] make_frame(
        input mgmt_op_e          op,
        input logic [REG_AW-1:0] phy,
        input logic [REG_AW-1:0] regn,
        input logic [DATA_W-1:0] data
    );
        logic [1:0]        opc;
        logic [1:0]        ta;
        logic [DATA_W-1:0] pay;
        opc = (op == OP_WR) ? 2'b01 : 2'b10;
        ta  = (op == OP_WR) ? 2'b10 : 2'b11;
        pay = (op == OP_WR) ? data  : '1;
        return {{PREAMBLE_BITS{1'b1}}, 2'b01, opc, phy, regn, ta, pay};
    endfunction

endpackage

// File: rtl/mii_mgmt_timebase.sv
module mii_mgmt_timebase
    import mii_mgmt_pkg::*;
#(
    parameter int MDC_HALF = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    output logic             mdc,
    output logic             bit_end,
    output logic             done,
    output logic [BIT_W-1:0] bit_idx
);
    localparam int PERIOD = 2 * MDC_HALF;
    localparam int PH_W   = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    typedef struct packed {
        logic [PH_W-1:0]  phase;
        logic [BIT_W-1:0] bitn;
    } tb_state_t;

    tb_state_t s_d, s_q;
    logic      last_phase;

    always_comb begin
        s_d        = s_q;
        last_phase = (s_q.phase == PH_W'(PERIOD - 1));
        bit_end    = run && last_phase;
        done       = bit_end && (s_q.bitn == BIT_W'(FRAME_BITS - 1));
        if (start) begin
            s_d = '0;
        end else if (run) begin
            if (last_phase) begin
                s_d.phase = '0;
                s_d.bitn  = s_q.bitn + BIT_W'(1);
            end else begin
                s_d.phase = s_q.phase + PH_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mdc     = run && (s_q.phase >= PH_W'(MDC_HALF));
    assign bit_idx = s_q.bitn;

endmodule

// File: rtl/mii_mgmt_serializer.sv
module mii_mgmt_serializer
    import mii_mgmt_pkg::*;
#(
    parameter logic [REG_AW-1:0] PHY_ADDR = 5'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              run,
    input  mgmt_op_e          op_i,
    input  logic [REG_AW-1:0] regn_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              bit_end,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rd_word
);
    typedef struct packed {
        logic [FRAME_BITS-1:0] frame;
        mgmt_op_e              op;
        logic [DATA_W-1:0]     cap;
    } ser_state_t;

    ser_state_t s_d, s_q;
    logic       released;

    always_comb begin
        s_d = s_q;
        if (start) begin
            s_d.frame = make_frame(op_i, PHY_ADDR, regn_i, wdata_i);
            s_d.op    = op_i;
        end else if (bit_end) begin
            s_d.frame = {s_q.frame[FRAME_BITS-2:0], 1'b1};
            s_d.cap   = {s_q.cap[DATA_W-2:0], mdio_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.frame <= '1;
            s_q.op    <= OP_RD;
            s_q.cap   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // Bus handed to the PHY from the turnaround onward on a read.
    assign released = (s_q.op == OP_RD) && (bit_idx >= BIT_W'(TA_FIRST_BIT));
    assign mdio_o   = run ? s_q.frame[FRAME_BITS-1] : 1'b1;
    assign mdio_oe  = run && !released;
    assign rd_word  = {s_q.cap[DATA_W-2:0], mdio_i};

endmodule

// File: rtl/mii_mgmt_ctrl.sv
module mii_mgmt_ctrl
    import mii_mgmt_pkg::*;
#(
    parameter int MDC_HALF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              done,
    input  logic [DATA_W-1:0] rd_word,
    output logic              start,
    output mgmt_op_e          start_op,
    output logic [REG_AW-1:0] regn,
    output logic [DATA_W-1:0] wdata,
    output logic              busy
);
    localparam int FRAME_CYC = FRAME_BITS * 2 * MDC_HALF;
    localparam int CNT_W     = $clog2(FRAME_CYC + 1) + 1;

    typedef struct packed {
        logic [REG_AW-1:0] regn;
        logic [1:0]        cmd;
        logic [7:0]        wlo;
        logic [7:0]        whi;
        logic [DATA_W-1:0] rdat;
        logic              nvalid;
        logic              busy;
        mgmt_op_e          op;
    } ctl_state_t;

    ctl_state_t s_d, s_q;
    logic       wr_ok;
    logic       start_rd;
    logic       start_wr;

    always_comb begin
        s_d      = s_q;
        wr_ok    = cfg_we && !s_q.busy;
        start_rd = wr_ok && (reg_idx_e'(cfg_addr) == RI_CMD) && cfg_wdata[0];
        start_wr = wr_ok && (reg_idx_e'(cfg_addr) == RI_WHI);
        if (wr_ok) begin
            case (reg_idx_e'(cfg_addr))
                RI_REGNUM: s_d.regn = cfg_wdata[REG_AW-1:0];
                RI_CMD:    s_d.cmd  = cfg_wdata[1:0];
                RI_WLO:    s_d.wlo  = cfg_wdata;
                RI_WHI:    s_d.whi  = cfg_wdata;
                default:   ;
            endcase
        end
        if (start_rd) begin
            s_d.busy   = 1'b1;
            s_d.op     = OP_RD;
            s_d.nvalid = 1'b1;
        end else if (start_wr) begin
            s_d.busy = 1'b1;
            s_d.op   = OP_WR;
        end else if (done) begin
            s_d.busy = 1'b0;
            if (s_q.op == OP_RD) begin
                s_d.rdat   = rd_word;
                s_d.nvalid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.nvalid <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (reg_idx_e'(cfg_addr))
            RI_REGNUM: cfg_rdata = {{(8-REG_AW){1'b0}}, s_q.regn};
            RI_CMD:    cfg_rdata = {6'b0, s_q.cmd};
            RI_WLO:    cfg_rdata = s_q.wlo;
            RI_WHI:    cfg_rdata = s_q.whi;
            RI_RLO:    cfg_rdata = s_q.rdat[7:0];
            RI_RHI:    cfg_rdata = s_q.rdat[15:8];
            RI_STAT:   cfg_rdata = {5'b0, s_q.nvalid, 1'b0, s_q.busy};
            default:   cfg_rdata = 8'h00;
        endcase
    end

    assign start    = start_rd || start_wr;
    assign start_op = start_wr ? OP_WR : OP_RD;
    assign regn     = s_q.regn;
    assign wdata    = {cfg_wdata, s_q.wlo};
    assign busy     = s_q.busy;

    // Independent measure of the busy window.
    logic [CNT_W-1:0] busy_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        busy_len_q <= '0;
        else if (start)    busy_len_q <= '0;
        else if (s_q.busy) busy_len_q <= busy_len_q + CNT_W'(1);
    end

    assert_busy_follows_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (s_q.busy && (s_q.op != OP_RD || s_q.nvalid)));

    assert_busy_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.busy) |-> (busy_len_q == CNT_W'(FRAME_CYC)));

    assert_read_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && s_q.op == OP_RD) |=> (!s_q.nvalid && s_q.rdat == $past(rd_word)));

    assert_regnum_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && cfg_we && reg_idx_e'(cfg_addr) == RI_REGNUM) |=> $stable(s_q.regn));

endmodule

// File: rtl/mii_mgmt_seq.sv
module mii_mgmt_seq
    import mii_mgmt_pkg::*;
#(
    parameter int                MDC_HALF = 4,
    parameter logic [REG_AW-1:0] PHY_ADDR = 5'd1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [2:0] cfg_addr,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic       mdio_i,
    output logic       mdc,
    output logic       mdio_o,
    output logic       mdio_oe
);
    logic              start;
    mgmt_op_e          start_op;
    logic [REG_AW-1:0] regn;
    logic [DATA_W-1:0] wdata;
    logic              busy;
    logic              bit_end;
    logic              done;
    logic [BIT_W-1:0]  bit_idx;
    logic [DATA_W-1:0] rd_word;

    mii_mgmt_ctrl #(.MDC_HALF(MDC_HALF)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .done      (done),
        .rd_word   (rd_word),
        .start     (start),
        .start_op  (start_op),
        .regn      (regn),
        .wdata     (wdata),
        .busy      (busy)
    );

    mii_mgmt_timebase #(.MDC_HALF(MDC_HALF)) u_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .run     (busy),
        .mdc     (mdc),
        .bit_end (bit_end),
        .done    (done),
        .bit_idx (bit_idx)
    );

    mii_mgmt_serializer #(.PHY_ADDR(PHY_ADDR)) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .run     (busy),
        .op_i    (start_op),
        .regn_i  (regn),
        .wdata_i (wdata),
        .bit_end (bit_end),
        .bit_idx (bit_idx),
        .mdio_i  (mdio_i),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .rd_word (rd_word)
    );

    assert_mdc_low_at_edges_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) || $fell(busy)) |-> !mdc);

    assert_mdio_still_while_mdc_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> $stable(mdio_o));

endmodule

// File: tb/test_mii_mgmt_seq.sv
`timescale 1ns/1ps
module test_mii_mgmt_seq;
    localparam int       H      = 2;
    localparam int       P      = 2 * H;
    localparam int       FCYC   = 64 * P;
    localparam bit [4:0] PHYA   = 5'h11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = 3'd0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       mdio_i;
    logic       mdc, mdio_o, mdio_oe;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    mii_mgmt_seq #(.MDC_HALF(H), .PHY_ADDR(PHYA)) i_mii_mgmt_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mdio_i(mdio_i),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    // ---------------- PHY model ----------------
    logic [15:0] pmem [32];
    logic [63:0] psh;
    int          pcnt;
    bit          prd;
    logic [4:0]  preg;
    logic        pdrv = 1'b1;
    assign mdio_i = pdrv;

    initial begin
        for (int i = 0; i < 32; i++) pmem[i] = 16'(i * 16'h0101) ^ 16'h5A00;
        pmem[2] = 16'h0083;
        pmem[3] = 16'h1403;
        psh = '0; pcnt = 0; prd = 0; preg = '0;
    end

    always @(posedge mdc) begin
        psh  = {psh[62:0], mdio_o};
        pcnt = pcnt + 1;
        if (pcnt == 46) begin
            prd  = (psh[11:10] == 2'b10) && (psh[9:5] == PHYA);
            preg = psh[4:0];
        end
        if (pcnt == 64) begin
            if (psh[29:28] == 2'b01 && psh[27:23] == PHYA) pmem[psh[22:18]] = psh[15:0];
            pcnt = 0;
            prd  = 0;
        end
    end

    always @(negedge mdc) begin
        if (prd && pcnt == 47)      pdrv = 1'b0;
        else if (prd && pcnt >= 48) pdrv = pmem[preg][63 - pcnt];
        else                        pdrv = 1'b1;
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        cfg_addr = a;
        #1;
        v = cfg_rdata;
    endtask

    // Called at a negedge, returns at the following negedge.
    task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] r, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), PHYA, r,
                (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : d)};
    endfunction

    // Starts on the first busy negedge; returns on the first idle negedge.
    task automatic run_frame(input bit rd, input logic [4:0] r, input logic [15:0] d);
        logic [63:0] ef;
        logic [7:0]  st;
        int i, mdc_err, bit_err, oe_err;
        ef = exp_frame(rd, r, d);
        i = 0; mdc_err = 0; bit_err = 0; oe_err = 0;
        peek(3'd6, st);
        while (st[0] && i < FCYC + 8) begin
            if (mdc !== ((i % P) >= H)) mdc_err++;
            if ((i % P) == P - 1) begin
                int b;
                b = i / P;
                if (mdio_oe !== (!rd || b < 46)) oe_err++;
                if ((!rd || b < 46) && mdio_o !== ef[63 - b]) bit_err++;
            end
            @(negedge clk);
            i++;
            peek(3'd6, st);
        end
        check("R4 busy length", i, FCYC);
        check("R5 mdc waveform errors", mdc_err, 0);
        check("R6 frame bit errors", bit_err, 0);
        check("R7 output enable errors", oe_err, 0);
        check("R5 mdc low when idle", mdc, 0);
    endtask

    task automatic do_write(input logic [4:0] r, input logic [15:0] d);
        logic [7:0] st;
        cfg_write(3'd0, {3'b0, r});
        cfg_write(3'd2, d[7:0]);
        peek(3'd6, st);
        check("R3 low byte does not launch", st[0], 0);
        cfg_write(3'd3, d[15:8]);
        peek(3'd6, st);
        check("R3 high byte launches", st[0], 1);
        run_frame(0, r, d);
    endtask

    task automatic do_read(input logic [4:0] r, output logic [15:0] v);
        logic [7:0] st, lo, hi;
        cfg_write(3'd0, {3'b0, r});
        cfg_write(3'd1, 8'h01);
        peek(3'd6, st);
        check("R2 busy and not-valid after read launch", st, 8'h05);
        run_frame(1, r, 16'h0);
        peek(3'd6, st);
        check("R8 not-valid clears with busy", st, 8'h00);
        peek(3'd4, lo);
        peek(3'd5, hi);
        v = {hi, lo};
        @(negedge clk);
        cfg_write(3'd1, 8'h00);
    endtask

    function automatic logic [15:0] pat(input int r);
        return 16'(r * 16'h0B3D) ^ 16'hC35A;
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // ---------------- scenarios ----------------
    initial begin
        logic [7:0]  v;
        logic [15:0] rv;
        repeat (3) @(negedge clk);
        peek(3'd6, v); check("R1 reset status", v, 8'h04);
        peek(3'd4, v); check("R1 reset read low", v, 0);
        peek(3'd5, v); check("R1 reset read high", v, 0);
        check("R1 mdc in reset", mdc, 0);
        check("R1 oe in reset", mdio_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 register index map
        cfg_write(3'd0, 8'hFF); peek(3'd0, v); check("R11 regnum width", v, 8'h1F);
        cfg_write(3'd2, 8'hA7); peek(3'd2, v); check("R11 data low", v, 8'hA7);
        peek(3'd7, v); check("R11 index 7 zero", v, 0);
        peek(3'd6, v); check("R3 data low write is inert", v, 8'h04);

        // R10 scan request stored, inert
        cfg_write(3'd1, 8'h02);
        peek(3'd1, v); check("R10 command readback", v, 8'h02);
        begin
            int bad;
            bad = 0;
            for (int k = 0; k < 20; k++) begin
                peek(3'd6, v);
                if (v !== 8'h04 || mdc !== 1'b0) bad++;
                @(negedge clk);
            end
            check("R10 scan starts no frame", bad, 0);
        end
        cfg_write(3'd1, 8'h00);

        // Identifier reads
        do_read(5'd2, rv); check("R8 identifier word 1", rv, 16'h0083);
        do_read(5'd3, rv); check("R8 identifier word 2 masked", rv & 16'hFC00, 16'h1400);

        // Sweep: write all, read all back
        for (int r = 0; r < 32; r++) do_write(5'(r), pat(r));
        for (int r = 0; r < 32; r++) begin
            do_read(5'(r), rv);
            check($sformatf("R8 read back reg %0d", r), rv, pat(r));
        end

        // R9: writes during busy ignored; R8: write frame leaves read data alone
        cfg_write(3'd0, 8'h07);
        cfg_write(3'd2, 8'h34);
        cfg_write(3'd3, 8'h12);
        cfg_write(3'd0, 8'h09);
        cfg_write(3'd2, 8'h77);
        cfg_write(3'd3, 8'h66);
        cfg_write(3'd1, 8'h01);
        begin
            int guard;
            guard = 0;
            peek(3'd6, v);
            while (v[0] && guard < FCYC + 8) begin
                @(negedge clk); guard++; peek(3'd6, v);
            end
        end
        peek(3'd0, v); check("R9 regnum kept", v, 8'h07);
        peek(3'd2, v); check("R9 data low kept", v, 8'h34);
        peek(3'd3, v); check("R9 data high kept", v, 8'h12);
        peek(3'd1, v); check("R9 command kept", v, 8'h00);
        peek(3'd4, v); check("R8 write frame keeps read low", v, pat(31) & 16'hFF);
        peek(3'd5, v); check("R8 write frame keeps read high", v, pat(31) >> 8);
        begin
            int bad;
            bad = 0;
            for (int k = 0; k < 12; k++) begin
                peek(3'd6, v);
                if (v !== 8'h00) bad++;
                @(negedge clk);
            end
            check("R9 no second frame", bad, 0);
        end
        do_read(5'd7, rv); check("R9 launched write landed", rv, 16'h1234);
        do_read(5'd9, rv); check("R9 ignored write not sent", rv, pat(9));

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule